// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request stream and an external asynchronous static RAM of 128K bytes. It accepts one single-beat request at a time (read or write, 17-bit word address, 8-bit data) over a valid/ready handshake. It then plays out the strobe sequence the RAM needs, with chip-enable, output-enable and write-enable all active low. The data pins of the RAM are shared in both directions. The block drives an output value and an output-enable for the pad driver, and it receives the pad's input value.

Every access walks through four phases: address setup with all strobes high, an active phase with the strobes asserted, a recovery phase with all strobes high, and then back to idle. Each phase lasts a whole number of clock cycles set by a parameter. The integrator rounds the RAM's nanosecond limits up to clock counts at the chosen frequency. These limits are address-to-data delay, write pulse width, data setup before the write ends, and bus release. Read data is sampled on the clock edge that closes the active phase. It is returned with a single-cycle response flag and no back-pressure on the response side. On the request side, ready is high only while the block is idle. A request is taken on the edge where valid and ready are both high. The requester is free to change or withdraw valid at any time while ready is low, and nothing it presents then is used.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip-enable, output-enable and write-enable are high (inactive), the data driver enable is low, ready is high and the response flag is low.
- R2: Ready is high only in idle. A request is taken only on an edge where valid and ready are both high. Ready is low from the next cycle until the access has finished. Valid asserted while ready is low has no effect on the RAM contents.
- R3: Chip-enable is low only during the active phase. It stays low for ACCESS_CYC cycles on a read and WPULSE_CYC cycles on a write, and it is never low while ready is high.
- R4: The address output takes the request address on acceptance and does not change until ready returns. Chip-enable falls SETUP_CYC cycles after the acceptance edge.
- R5: On a read, output-enable is low for exactly ACCESS_CYC cycles, always together with chip-enable low and write-enable high. Write-enable never goes low during a read.
- R6: On a read, the response flag is high for exactly one cycle, SETUP_CYC+ACCESS_CYC cycles after acceptance. The read data output holds the sampled byte until the next read samples again. A write produces no response.
- R7: On a write, output-enable stays high throughout. Chip-enable and write-enable are low together for exactly WPULSE_CYC cycles and rise on the same clock edge.
- R8: On a write, the data driver is enabled with the request byte from the first setup cycle until one cycle after the strobes rise, and the byte is stable over that window. On a read, the driver is off.
- R9: The data driver enable and output-enable are never active in the same cycle.
- R10: Ready returns SETUP_CYC+ACCESS_CYC+RECOV_CYC cycles after acceptance for a read, and SETUP_CYC+WPULSE_CYC+RECOV_CYC cycles after acceptance for a write. At least one cycle with all strobes high follows each active phase.
- R11: A read of any address returns the byte most recently written to it (zero for an address never written in the bench's RAM model).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W (8) | Last byte read |
| sram_addr | output | ADDR_W (17) | RAM address pins |
| sram_ce_n | output | 1 | RAM chip-enable, active low |
| sram_oe_n | output | 1 | RAM output-enable, active low |
| sram_we_n | output | 1 | RAM write-enable, active low |
| sram_dq_out | output | DATA_W (8) | Value for the data pad driver |
| sram_dq_oe | output | 1 | Data pad driver enable, active high |
| sram_dq_in | input | DATA_W (8) | Value seen on the data pins |

## Verification
The assertions assume that every phase count parameter is at least one and that the requester raises valid only with settled address, write flag and data. They also assume that the external RAM releases the data pins within the recovery phase. The stimulus offers requests only at clock falling edges and holds the fields steady across the accepting edge. A few requests additionally raise valid while the block is busy, so that the back-pressure rule is exercised. The bench RAM model returns a marker byte until output-enable has been low for ACCESS_CYC cycles. As a result, only a read sampled at the right edge sees real data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  localparam int MAXC  = max4(SETUP_CYC, ACCESS_CYC, WPULSE_CYC, RECOV_CYC);
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LEN    = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LEN    = CNT_W'(WPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LEN   = CNT_W'(RECOV_CYC - 1);

  phase_e           state_q, state_d;
  logic             wr_q, wr_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          state_d  = PH_SETUP;
          wr_d     = req_write;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LEN;
        end
      end
      PH_SETUP: begin
        if (tmr_done) begin
          state_d  = PH_ACTIVE;
          tmr_load = 1'b1;
          tmr_val  = wr_q ? WR_LEN : RD_LEN;
        end
      end
      PH_ACTIVE: begin
        if (tmr_done) begin
          state_d  = PH_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = REC_LEN;
        end
      end
      PH_RECOVER: begin
        if (tmr_done) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      ce_n    <= (state_d != PH_ACTIVE);
      oe_n    <= !((state_d == PH_ACTIVE) && !wr_d);
      we_n    <= !((state_d == PH_ACTIVE) && wr_d);
      dq_oe   <= wr_d && ((state_d == PH_SETUP) || (state_d == PH_ACTIVE) ||
                          ((state_d == PH_RECOVER) && (state_q == PH_ACTIVE)));
    end
  end

  assign req_ready = (state_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == PH_ACTIVE) && tmr_done && !wr_q;

  assert_read_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));
  assert_write_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));
  assert_rise_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $rose(ce_n));
  assert_recover_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> ce_n);
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  assert_ce_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              dq_oe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (accept) begin
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= sram_dq_in;
    end
  end

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> $past(accept));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(sram_dq_out));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 2,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  logic accept;
  logic capture;

  asram_sequencer #(
    .SETUP_CYC  (SETUP_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .WPULSE_CYC (WPULSE_CYC),
    .RECOV_CYC  (RECOV_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe)
  );

  asram_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .capture     (capture),
    .dq_oe       (sram_dq_oe),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  assert_ce_falls_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_ce_n) |-> $stable(sram_addr));

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int S  = 1;
  localparam int A  = 2;
  localparam int W  = 2;
  localparam int R  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n;
  logic [DW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_in;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .ACCESS_CYC(A),
               .WPULSE_CYC(W), .RECOV_CYC(R)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural RAM model with access delay
  logic [7:0] mem [int];
  logic [7:0] sb  [int];
  int         oe_age = 0;
  logic [7:0] model_q = 8'h00;
  bit         prev_wr = 1'b0;
  int         wcnt = 0;
  logic [7:0] wdat = 8'h00;
  logic [AW-1:0] waddr = '0;

  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n && oe_age >= A) ? model_q : 8'hA5;

  always @(negedge clk) begin
    if (rst_n) begin
      bit wr_now;
      wr_now = !sram_ce_n && !sram_we_n;
      check(!(sram_dq_oe && !sram_oe_n), "R9 driver vs output-enable", int'(sram_dq_oe), 0);
      check(!(req_ready && !sram_ce_n), "R3 chip-enable while idle", int'(sram_ce_n), 1);
      if (wr_now) begin
        if (wcnt == 0) begin
          wdat  = sram_dq_out;
          waddr = sram_addr;
        end
        check(sram_dq_oe && sram_dq_out == wdat && sram_oe_n, "R8 write data during pulse",
              int'(sram_dq_out), int'(wdat));
        wcnt++;
      end else if (prev_wr) begin
        check(wcnt == W, "R7 write pulse length", wcnt, W);
        check(sram_dq_oe && sram_dq_out == wdat, "R8 data hold after pulse",
              int'(sram_dq_out), int'(wdat));
        mem[int'(waddr)] = wdat;
        wcnt = 0;
      end
      prev_wr = wr_now;
      oe_age  = sram_oe_n ? 0 : oe_age + 1;
      model_q = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    end
  end

  task automatic run_req(input logic [AW-1:0] a, input bit wr, input logic [7:0] d, input bit poke);
    int n, rsp_n, rsp_cnt, ce_lo, oe_lo, we_lo, first_ce;
    logic [7:0] got, expv;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    expv = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
    if (wr) sb[int'(a)] = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; rsp_n = 0; rsp_cnt = 0; ce_lo = 0; oe_lo = 0; we_lo = 0; first_ce = 0; got = '0;
    check(!req_ready, "R2 ready after accept", int'(req_ready), 0);
    check(sram_dq_oe == wr && (!wr || sram_dq_out == d), "R8 driver in setup",
          int'(sram_dq_oe), int'(wr));
    while (!req_ready && n < 1000) begin
      if (poke && n == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 17'h1; req_wdata = ~d;
      end
      if (poke && n == 3) req_valid = 1'b0;
      check(sram_addr == a, "R4 address held", int'(sram_addr), int'(a));
      if (!sram_ce_n) begin
        ce_lo++;
        if (first_ce == 0) first_ce = n;
      end
      if (!sram_oe_n) oe_lo++;
      if (!sram_we_n) we_lo++;
      if (rsp_valid) begin rsp_cnt++; rsp_n = n; got = rsp_rdata; end
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(first_ce == S + 1, "R4 setup before chip-enable", first_ce, S + 1);
    check(ce_lo == (wr ? W : A), "R3 chip-enable length", ce_lo, wr ? W : A);
    check(n == (wr ? S + W + R + 1 : S + A + R + 1), "R10 occupancy", n,
          wr ? S + W + R + 1 : S + A + R + 1);
    if (wr) begin
      check(oe_lo == 0, "R7 output-enable high in write", oe_lo, 0);
      check(we_lo == W, "R7 write-enable length", we_lo, W);
      check(rsp_cnt == 0, "R6 no response on write", rsp_cnt, 0);
    end else begin
      check(oe_lo == A && we_lo == 0, "R5 read strobes", oe_lo, A);
      check(rsp_cnt == 1 && rsp_n == S + A + 1, "R6 response timing", rsp_n, S + A + 1);
      check(got == expv, "R11 read data", int'(got), int'(expv));
      check(rsp_rdata == got, "R6 read data held", int'(rsp_rdata), int'(got));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [8];
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_valid,
          "R1 during reset", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_valid,
          "R1 after reset", {sram_ce_n, sram_oe_n, sram_we_n}, 7);

    // directed corners (R11)
    run_req(17'h00000, 1'b1, 8'h3C, 1'b0);
    run_req(17'h00000, 1'b0, 8'h00, 1'b0);
    run_req(17'h1FFFF, 1'b1, 8'hFF, 1'b0);
    run_req(17'h1FFFF, 1'b0, 8'h00, 1'b0);
    run_req(17'h0ABCD, 1'b1, 8'h00, 1'b0);
    run_req(17'h0ABCD, 1'b1, 8'h81, 1'b0);
    run_req(17'h0ABCD, 1'b0, 8'h00, 1'b0);
    run_req(17'h12345, 1'b0, 8'h00, 1'b0);
    // back-pressure: valid raised while busy must not write (R2)
    run_req(17'h00100, 1'b1, 8'h77, 1'b1);
    run_req(17'h00101, 1'b0, 8'h00, 1'b0);
    run_req(17'h00100, 1'b0, 8'h00, 1'b1);
    run_req(17'h00101, 1'b0, 8'h00, 1'b0);

    // constrained random traffic
    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom) ;
    for (int i = 0; i < 400; i++) begin
      int gap;
      run_req(pool[$urandom % 8], bit'($urandom % 2), 8'($urandom), bit'(($urandom % 16) == 0));
      gap = int'($urandom % 3);
      repeat (gap) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule